// File: doc/BRIEF.md
# Inter-Processor Mailbox with Per-User Interrupts

This block lets several processors on one chip exchange 32-bit words through a set of independent hardware queues behind a small register bus. A sender writes a word into a queue's message register, and a receiver reads the same register to take the oldest word out. Status registers let software check whether a queue is full and how many words it holds.

Every user of the block (normally one per processor) has its own interrupt output. Each user also has a sticky event word with two bits per queue: one bit marks the arrival of a word, and the other marks that the queue has just stopped being full. A per-user mask selects which events drive that user's interrupt line. Software clears events by writing ones.

A build-time option picks between two register layouts for the interrupt words. The compact layout has a status word and a directly written enable word for each user. The wide layout has a status word, an enable-set word and an enable-clear word for each user.

Top module: `ipc_mailbox`

## Requirements
- R1: A read at byte offset 0x000 returns the revision, with the major number in bits [7:4] and the minor number in bits [3:0] (defaults 1 and 2, so 0x12). A write to that offset has no effect.
- R2: Queue m's message register is at 0x040 + 4*m. A write appends the word to the queue. A read returns the oldest word and removes it, so words come out in the order they were written.
- R3: Queue m holds at most DEPTH words (default 4). A write to a full queue is discarded. The register at 0x080 + 4*m reads 1 while the queue is full and 0 otherwise.
- R4: The register at 0x0C0 + 4*m reads the number of words in queue m. A read of the message register of an empty queue returns 0 and leaves the queue unchanged.
- R5: Each accepted write into queue m sets bit 2*m in the event word of every user.
- R6: A read that takes queue m from full to not full sets bit 2*m+1 in the event word of every user.
- R7: In the compact layout, user u's event word is at 0x100 + 8*u. Event bits stay set until they are cleared. Writing a 1 to a bit clears it, and writing a 0 leaves it unchanged.
- R8: In the compact layout, user u's enable word is at 0x104 + 8*u. A write loads the whole mask, and a read returns it.
- R9: User u's interrupt output is high exactly when some bit is set in both u's event word and u's enable word.
- R10: In the wide layout, user u's event word is at 0x104 + 0x10*u, its enable-set word at 0x108 + 0x10*u and its enable-clear word at 0x10C + 0x10*u. Writing ones to the set word turns those enable bits on. Writing ones to the clear word turns them off. Both words read back the mask. Event bits are still cleared by writing ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid in the same cycle as the read strobe |
| irq_out | output | NUSERS | One interrupt line per user |

## Verification
The checker watches on every cycle:
- that no queue count exceeds the depth;
- that a write to a full queue and a read from an empty queue leave the count unchanged;
- that an accepted write or a full-to-not-full read raises the matching event bit for every user in the next cycle;
- that event bits only drop in a cycle with a clear write;
- that an interrupt stays low while its mask or its event word is zero.

Some behaviour only the bench scenarios can show: word order through a queue, the data returned by an empty read, register offsets and readback values, and the enable set and clear behaviour of the wide layout. The bench shows these against a behavioural model, which also predicts every interrupt line on every clock.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int unsigned OFS_REV      = 'h000;
   localparam int unsigned OFS_MSG      = 'h040;
   localparam int unsigned OFS_FULLST   = 'h080;
   localparam int unsigned OFS_CNTST    = 'h0C0;
   localparam int unsigned OFS_IRQ_BASE = 'h100;

   typedef enum logic {LAYOUT_COMPACT = 1'b0, LAYOUT_WIDE = 1'b1} layout_e;

   function automatic int unsigned msg_ofs(input int unsigned q);
      return OFS_MSG + 4 * q;
   endfunction

   function automatic int unsigned fullst_ofs(input int unsigned q);
      return OFS_FULLST + 4 * q;
   endfunction

   function automatic int unsigned cntst_ofs(input int unsigned q);
      return OFS_CNTST + 4 * q;
   endfunction

   // Interrupt block offsets: stat, enable(-set), enable-clear
   function automatic int unsigned stat_ofs(input int unsigned u, input layout_e lay);
      return (lay == LAYOUT_WIDE) ? OFS_IRQ_BASE + 'h4 + 'h10 * u : OFS_IRQ_BASE + 8 * u;
   endfunction

   function automatic int unsigned ena_ofs(input int unsigned u, input layout_e lay);
      return (lay == LAYOUT_WIDE) ? OFS_IRQ_BASE + 'h8 + 'h10 * u : OFS_IRQ_BASE + 'h4 + 8 * u;
   endfunction

   function automatic int unsigned enclr_ofs(input int unsigned u);
      return OFS_IRQ_BASE + 'hC + 'h10 * u;
   endfunction
endpackage

// File: rtl/mbx_queue.sv
module mbx_queue #(
   parameter int unsigned DW    = 32,
   parameter int unsigned DEPTH = 4,
   parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] head,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty,
   output logic          push_ok,
   output logic          nf_evt
);
   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic          pop_ok;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign nf_evt  = pop_ok && full;
   assign head    = mem[rd_ptr];

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= bump(wr_ptr);
         if (pop_ok)  rd_ptr <= bump(rd_ptr);
         case ({push_ok, pop_ok})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= wdata;
   end
endmodule

// File: rtl/mbx_irq_user.sv
module mbx_irq_user #(
   parameter int unsigned NB = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NB-1:0] set_evt,
   input  logic          clr_we,
   input  logic          en_load,
   input  logic          en_set,
   input  logic          en_clr,
   input  logic [NB-1:0] wbits,
   output logic [NB-1:0] status,
   output logic [NB-1:0] enable,
   output logic          irq
);
   logic [NB-1:0] clr_mask;

   assign clr_mask = clr_we ? wbits : '0;
   assign irq      = |(status & enable);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
         enable <= '0;
      end else begin
         // new events override a clear in the same cycle
         status <= (status & ~clr_mask) | set_evt;
         if (en_load)     enable <= wbits;
         else if (en_set) enable <= enable | wbits;
         else if (en_clr) enable <= enable & ~wbits;
      end
   end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
   import mbx_pkg::*;
#(
   parameter int unsigned DW        = 32,
   parameter int unsigned AW        = 9,
   parameter int unsigned NQ        = 4,
   parameter int unsigned DEPTH     = 4,
   parameter int unsigned NUSERS    = 2,
   parameter int unsigned REV_MAJOR = 1,
   parameter int unsigned REV_MINOR = 2,
   parameter layout_e     LAYOUT    = LAYOUT_COMPACT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [AW-1:0]     bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic [NUSERS-1:0] irq_out
);
   localparam int unsigned NB = 2 * NQ;
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam int unsigned TOP_OFS = OFS_IRQ_BASE + 'h10 * NUSERS;

   if (NB > DW)            begin : g_bad_nb   $error("two event bits per queue must fit the data word"); end
   if (NQ > 16)            begin : g_bad_nq   $error("queue window holds at most 16 queues"); end
   if (DEPTH < 2)          begin : g_bad_dep  $error("queue depth must be at least 2"); end
   if (TOP_OFS > (1 << AW)) begin : g_bad_aw  $error("address width too small for the map"); end
   if (REV_MAJOR > 15 || REV_MINOR > 15) begin : g_bad_rev $error("revision fields are 4 bits"); end

   logic                     rd_acc, wr_acc;
   logic [NQ-1:0]            q_push, q_pop, q_full, q_empty, q_push_ok, q_nf;
   logic [NQ-1:0][DW-1:0]    q_head;
   logic [NQ-1:0][CW-1:0]    q_cnt;
   logic [NB-1:0]            evt;
   logic [NUSERS-1:0]        st_hit, en_hit, clr_hit;
   logic [NUSERS-1:0]        usr_clr_we, usr_load, usr_set, usr_clr;
   logic [NUSERS-1:0][NB-1:0] usr_stat, usr_en;

   assign rd_acc = bus_sel && !bus_wr;
   assign wr_acc = bus_sel && bus_wr;

   // queues
   for (genvar q = 0; q < NQ; q++) begin : g_q
      logic hit;
      assign hit       = bus_sel && (bus_addr == AW'(msg_ofs(q)));
      assign q_push[q] = hit && bus_wr;
      assign q_pop[q]  = hit && !bus_wr;
      assign evt[2*q]   = q_push_ok[q];
      assign evt[2*q+1] = q_nf[q];

      mbx_queue #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_queue (
         .clk     (clk),
         .rst_n   (rst_n),
         .push    (q_push[q]),
         .pop     (q_pop[q]),
         .wdata   (bus_wdata),
         .head    (q_head[q]),
         .count   (q_cnt[q]),
         .full    (q_full[q]),
         .empty   (q_empty[q]),
         .push_ok (q_push_ok[q]),
         .nf_evt  (q_nf[q])
      );
   end

   // per-user interrupt blocks, layout chosen at build time
   for (genvar u = 0; u < NUSERS; u++) begin : g_usr
      assign st_hit[u] = bus_sel && (bus_addr == AW'(stat_ofs(u, LAYOUT)));
      assign en_hit[u] = bus_sel && (bus_addr == AW'(ena_ofs(u, LAYOUT)));
      assign usr_clr_we[u] = st_hit[u] && bus_wr;

      if (LAYOUT == LAYOUT_WIDE) begin : g_wide
         assign clr_hit[u]  = bus_sel && (bus_addr == AW'(enclr_ofs(u)));
         assign usr_load[u] = 1'b0;
         assign usr_set[u]  = en_hit[u] && bus_wr;
         assign usr_clr[u]  = clr_hit[u] && bus_wr;
      end else begin : g_compact
         assign clr_hit[u]  = 1'b0;
         assign usr_load[u] = en_hit[u] && bus_wr;
         assign usr_set[u]  = 1'b0;
         assign usr_clr[u]  = 1'b0;
      end

      mbx_irq_user #(.NB(NB)) u_irq (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_evt (evt),
         .clr_we  (usr_clr_we[u]),
         .en_load (usr_load[u]),
         .en_set  (usr_set[u]),
         .en_clr  (usr_clr[u]),
         .wbits   (bus_wdata[NB-1:0]),
         .status  (usr_stat[u]),
         .enable  (usr_en[u]),
         .irq     (irq_out[u])
      );
   end

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (rd_acc) begin
         if (bus_addr == AW'(OFS_REV))
            bus_rdata = DW'({REV_MAJOR[3:0], REV_MINOR[3:0]});
         for (int q = 0; q < NQ; q++) begin
            if (bus_addr == AW'(msg_ofs(q)) && !q_empty[q]) bus_rdata = q_head[q];
            if (bus_addr == AW'(fullst_ofs(q))) bus_rdata = DW'(q_full[q]);
            if (bus_addr == AW'(cntst_ofs(q)))  bus_rdata = DW'(q_cnt[q]);
         end
         for (int u = 0; u < NUSERS; u++) begin
            if (st_hit[u])              bus_rdata = DW'(usr_stat[u]);
            if (en_hit[u] || clr_hit[u]) bus_rdata = DW'(usr_en[u]);
         end
      end
   end

   logic unused_wr;
   assign unused_wr = wr_acc;
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
   parameter int unsigned NQ     = 4,
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned NUSERS = 2,
   parameter int unsigned CW     = 3,
   parameter int unsigned NB     = 8
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [NQ-1:0]             push,
   input logic [NQ-1:0]             pop,
   input logic [NQ-1:0][CW-1:0]     cnt,
   input logic [NUSERS-1:0][NB-1:0] stat,
   input logic [NUSERS-1:0][NB-1:0] en,
   input logic [NUSERS-1:0]         clr_we,
   input logic [NUSERS-1:0]         irq
);
   for (genvar q = 0; q < NQ; q++) begin : g_q
      p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
         cnt[q] <= CW'(DEPTH));
      p_drop_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (push[q] && cnt[q] == CW'(DEPTH)) |=> (cnt[q] == CW'(DEPTH)));
      p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (pop[q] && cnt[q] == '0) |=> (cnt[q] == '0));
      for (genvar u = 0; u < NUSERS; u++) begin : g_u
         p_newmsg_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (push[q] && cnt[q] < CW'(DEPTH)) |=> stat[u][2*q]);
         p_notfull_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (pop[q] && cnt[q] == CW'(DEPTH)) |=> stat[u][2*q+1]);
      end
   end

   for (genvar u = 0; u < NUSERS; u++) begin : g_usr
      p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !clr_we[u] |=> ((stat[u] & $past(stat[u])) == $past(stat[u])));
      p_irq_nomask_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (en[u] == '0) |-> !irq[u]);
      p_irq_noevt_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (stat[u] == '0) |-> !irq[u]);
   end
endmodule

bind ipc_mailbox mbx_chk #(
   .NQ(NQ), .DEPTH(DEPTH), .NUSERS(NUSERS), .CW(CW), .NB(NB)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .push   (q_push),
   .pop    (q_pop),
   .cnt    (q_cnt),
   .stat   (usr_stat),
   .en     (usr_en),
   .clr_we (usr_clr_we),
   .irq    (irq_out)
);

// File: tb/tb_ipc_mailbox.sv
module tb_ipc_mailbox;
   import mbx_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_m = 1'b0, sel_a = 1'b0, we = 1'b0;
   logic [8:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata_m, rdata_a;
   logic [1:0]  irq_m, irq_a;

   int checks = 0;
   int errors = 0;
   bit run = 0;

   always #5 clk = ~clk;

   ipc_mailbox dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel_m), .bus_wr(we), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata_m), .irq_out(irq_m));

   ipc_mailbox #(.LAYOUT(LAYOUT_WIDE)) dut_alt (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel_a), .bus_wr(we), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata_a), .irq_out(irq_a));

   // behavioural model of the compact-layout instance
   bit [31:0] mq [4][$];
   bit [7:0]  m_stat [2];
   bit [7:0]  m_en [2];

   function automatic bit [31:0] model_value(input bit [8:0] a);
      if (a == 0) return 32'h12;
      for (int q = 0; q < 4; q++) begin
         if (a == 9'(msg_ofs(q)))    return (mq[q].size() > 0) ? mq[q][0] : 32'h0;
         if (a == 9'(fullst_ofs(q))) return (mq[q].size() == 4) ? 32'h1 : 32'h0;
         if (a == 9'(cntst_ofs(q)))  return 32'(mq[q].size());
      end
      for (int u = 0; u < 2; u++) begin
         if (a == 9'('h100 + 8*u)) return 32'(m_stat[u]);
         if (a == 9'('h104 + 8*u)) return 32'(m_en[u]);
      end
      return 32'h0;
   endfunction

   function automatic void model_pop(input bit [8:0] a);
      for (int q = 0; q < 4; q++)
         if (a == 9'(msg_ofs(q)) && mq[q].size() > 0) begin
            if (mq[q].size() == 4)
               for (int u = 0; u < 2; u++) m_stat[u][2*q+1] = 1'b1;
            void'(mq[q].pop_front());
         end
   endfunction

   function automatic void model_write(input bit [8:0] a, input bit [31:0] d);
      for (int q = 0; q < 4; q++)
         if (a == 9'(msg_ofs(q)) && mq[q].size() < 4) begin
            mq[q].push_back(d);
            for (int u = 0; u < 2; u++) m_stat[u][2*q] = 1'b1;
         end
      for (int u = 0; u < 2; u++) begin
         if (a == 9'('h100 + 8*u)) m_stat[u] = m_stat[u] & ~d[7:0];
         if (a == 9'('h104 + 8*u)) m_en[u] = d[7:0];
      end
   endfunction

   function automatic bit [1:0] model_irq();
      bit [1:0] r;
      for (int u = 0; u < 2; u++) r[u] = |(m_stat[u] & m_en[u]);
      return r;
   endfunction

   task automatic check(input string tag, input bit [31:0] act, input bit [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // interrupt lines compared with the model on every clock
   always @(negedge clk) begin
      if (run) check("R9 irq lines", 32'(irq_m), 32'(model_irq()));
   end

   task automatic wr(input bit alt, input bit [8:0] a, input bit [31:0] d);
      @(negedge clk);
      sel_m = !alt; sel_a = alt; we = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      if (!alt) model_write(a, d);
   endtask

   task automatic rd(input bit [8:0] a, input string tag);
      bit [31:0] exp;
      @(negedge clk);
      sel_m = 1'b1; sel_a = 1'b0; we = 1'b0; addr = a;
      exp = model_value(a);
      #1 check(tag, rdata_m, exp);
      @(posedge clk);
      model_pop(a);
   endtask

   task automatic rd_alt(input bit [8:0] a, input bit [31:0] exp, input string tag);
      @(negedge clk);
      sel_m = 1'b0; sel_a = 1'b1; we = 1'b0; addr = a;
      #1 check(tag, rdata_a, exp);
      @(posedge clk);
   endtask

   task automatic idle();
      @(negedge clk);
      sel_m = 1'b0; sel_a = 1'b0; we = 1'b0;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      run = 1;
      // reset state
      check("R9 reset irq", 32'(irq_m), 32'h0);
      rd(9'h000, "R1 revision");
      wr(0, 9'h000, 32'hFFFF_FFFF);
      rd(9'h000, "R1 revision after write");
      for (int q = 0; q < 4; q++) rd(9'(cntst_ofs(q)), "R4 reset count");
      rd(9'h100, "R7 reset status");

      // order through queue 0, new-message events
      wr(0, 9'h040, 32'h1111_0001);
      wr(0, 9'h040, 32'h2222_0002);
      rd(9'h0C0, "R4 count two");
      rd(9'h100, "R5 user0 newmsg");
      rd(9'h108, "R5 user1 newmsg");
      wr(0, 9'h104, 32'h0000_0001);
      rd(9'h104, "R8 enable readback");
      wr(0, 9'h108, 32'h0);
      rd(9'h108, "R7 zero write keeps status");
      wr(0, 9'h100, 32'h1);
      rd(9'h100, "R7 w1c clears");
      rd(9'h040, "R2 first word");
      rd(9'h040, "R2 second word");
      rd(9'h040, "R4 empty read zero");
      rd(9'h0C0, "R4 count after empty read");

      // fill queue 1 past its depth
      for (int i = 0; i < 5; i++) wr(0, 9'h044, 32'hA000_0000 + 32'(i));
      rd(9'h084, "R3 full flag");
      rd(9'h0C4, "R3 count capped");
      rd(9'h080, "R3 other queue not full");
      wr(0, 9'h10C, 32'h0000_0008);
      rd(9'h044, "R2 q1 word0");
      rd(9'h084, "R3 full flag cleared");
      rd(9'h100, "R6 user0 notfull");
      rd(9'h108, "R6 user1 notfull");
      rd(9'h044, "R2 q1 word1");
      rd(9'h044, "R2 q1 word2");
      rd(9'h044, "R3 q1 word3 not the dropped one");
      rd(9'h044, "R4 q1 empty read");
      wr(0, 9'h108, 32'hFF);
      rd(9'h108, "R7 user1 cleared");
      wr(0, 9'h100, 32'hFF);

      // queue 3 interleaved with user-1 mask
      wr(0, 9'h10C, 32'h0000_0040);
      wr(0, 9'h04C, 32'hDEAD_BEEF);
      wr(0, 9'h04C, 32'h0BAD_F00D);
      rd(9'h04C, "R2 q3 word0");
      wr(0, 9'h04C, 32'h1234_5678);
      rd(9'h0CC, "R4 q3 count");
      rd(9'h04C, "R2 q3 word1");
      rd(9'h04C, "R2 q3 word2");
      wr(0, 9'h108, 32'h40);
      wr(0, 9'h104, 32'h0);
      idle();

      // wide layout instance
      wr(1, 9'h040, 32'h0000_00AA);
      rd_alt(9'h104, 32'h1, "R10 wide status user0");
      rd_alt(9'h114, 32'h1, "R10 wide status user1");
      idle();
      check("R10 irq masked", 32'(irq_a), 32'h0);
      wr(1, 9'h108, 32'h1);
      rd_alt(9'h108, 32'h1, "R10 enable set readback");
      idle();
      check("R10 irq user0 high", 32'(irq_a), 32'h1);
      wr(1, 9'h118, 32'h3);
      wr(1, 9'h10C, 32'h1);
      rd_alt(9'h10C, 32'h0, "R10 enable clear readback");
      rd_alt(9'h11C, 32'h3, "R10 user1 mask kept");
      idle();
      check("R10 irq after clear", 32'(irq_a), 32'h2);
      wr(1, 9'h114, 32'h1);
      rd_alt(9'h114, 32'h0, "R10 wide w1c");
      idle();
      check("R10 irq after w1c", 32'(irq_a), 32'h0);
      rd_alt(9'h040, 32'hAA, "R10 wide queue data");
      idle();

      repeat (2) @(negedge clk);
      run = 0;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule